// File: doc/BRIEF.md
# Real-time clock register window

This block puts a 128-byte register file behind a two-address, byte-wide bus. The file holds the clock, alarm, control and status bytes of a PC-style real-time clock. A write to the even address selects a byte. An access to the odd address then reads or writes the selected byte. Most bytes are plain storage. The control and status bytes follow their own rules:

- The busy flag in the first control byte is read-only.
- A write that enters freeze mode forces some bits to fixed values.
- The two status bytes ignore writes.
- Reading the interrupt status byte clears it and releases the interrupt line.
- A 16-bit checksum over a fixed block of configuration bytes is kept up to date in the same cycle as each write.

The block is the bus face of the clock, not the clock itself. A separate time counter takes the seven time/date bytes from `tm_image` whenever `tm_load` pulses. The counter drives the busy flag through `uip_set` and `uip_clr`, and writes its current time back through `tc_copy`. The interrupt logic reports events through `flag_set`.

Freeze mode is tracked by a two-state machine with states ST_RUN and ST_HOLD. It moves from ST_RUN to ST_HOLD on a control-B write with bit 7 high. It moves from ST_HOLD back to ST_RUN on a control-B write with bit 7 low, and that transition requests a counter reload. In ST_RUN a time-byte write requests a reload. In ST_HOLD it does not.

Top module: `rtcx_regs`

## Requirements
- R1: A write at the even address (`bus_a0`=0) stores `bus_wdata[6:0]` as the byte index, so bit 7 of the data is dropped. A read at the even address returns 0xFF.
- R2: Bit 7 of control A (index 10) keeps its value on bus writes. `uip_clr` clears that bit. `uip_set` sets it only while freeze mode is off.
- R3: A write to control B (index 11) with bit 7 set stores the byte with bit 4 forced to 0, clears bit 7 of control A, and enters ST_HOLD.
- R4: A control-B write with bit 7 clear, made while in ST_HOLD, pulses `tm_load` for one cycle after the write. The same write made in ST_RUN gives no pulse.
- R5: Bus writes to status C (index 12) and status D (index 13) have no effect.
- R6: A read of status C returns its current value. The byte is then cleared to 0x00 and `irq` drops. Flags that arrive in the same cycle as the read are kept.
- R7: A write to a time byte (indices 0, 2, 4, 6, 7, 8, 9) always stores the byte. It pulses `tm_load` on the next cycle only in ST_RUN.
- R8: After reset, control A reads 0x26, control B reads 0x02, status C reads 0x00, status D reads 0x80, and `irq` is low.
- R9: Index 0x2E holds the high byte and index 0x2F the low byte of the 16-bit sum of bytes 0x10 to 0x2D. The sum is correct on the access after any write in that range. Writes outside that range leave it unchanged.
- R10: A `tc_copy` pulse loads the seven time bytes from `tc_bytes` in ST_RUN. It is ignored in ST_HOLD. Both `tc_bytes` and `tm_image` pack the bytes as {idx9, idx8, idx7, idx6, idx4, idx2, idx0}, with index 0 in bits 7:0.
- R11: Any set bit of `flag_set` is ORed into status C and raises `irq` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | Address bit 0: 0 selects the index, 1 selects the data byte |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle the strobe is high |
| uip_set | input | 1 | Time counter: raise the busy flag |
| uip_clr | input | 1 | Time counter: drop the busy flag |
| flag_set | input | 8 | Interrupt logic: flag bits to OR into status C |
| irq | output | 1 | Interrupt request level |
| tc_copy | input | 1 | Time counter: write `tc_bytes` into the time bytes |
| tc_bytes | input | 56 | Time counter value, packed as in R10 |
| tm_image | output | 56 | Current time bytes, packed as in R10 |
| tm_load | output | 1 | One-cycle request to reload the counter from `tm_image` |
| ctrl_a | output | 8 | Control A byte |
| ctrl_b | output | 8 | Control B byte |

## Verification
The assertions assume the bus never raises `bus_wr` and `bus_rd` in the same cycle. They also assume each strobe is high for one cycle per access, and that `uip_set` and `uip_clr` are never both high. The freeze-mode checks rely on the control-B byte being changed only from the bus. The stimulus drives one access per task call, with an idle cycle between calls. It pulses each hook input alone, away from bus activity, except in one deliberate case where a flag arrives during a status-C read.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
    typedef enum logic {ST_RUN, ST_HOLD} mode_e;

    localparam int IDX_CTL_A  = 10;
    localparam int IDX_CTL_B  = 11;
    localparam int IDX_STAT_C = 12;
    localparam int IDX_STAT_D = 13;
    localparam int BUSY_BIT   = 7;
    localparam int FRZ_BIT    = 7;
    localparam int UEN_BIT    = 4;
    localparam int N_TIME     = 7;

    // slot k of the time image -> register index (0,2,4,6,7,8,9)
    function automatic int slot_idx(int k);
        return (k < 3) ? 2 * k : k + 3;
    endfunction

    function automatic logic is_time_idx(logic [6:0] i);
        return (i == 7'd0) || (i == 7'd2) || (i == 7'd4) || (i == 7'd6) ||
               (i == 7'd7) || (i == 7'd8) || (i == 7'd9);
    endfunction
endpackage

// File: rtl/rtcx_mode_fsm.sv
module rtcx_mode_fsm
    import rtcx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic b_wr,
    input  logic b_frz,
    input  logic time_wr,
    output logic set_mode,
    output logic tm_load
);
    mode_e st, st_nx;
    logic  load_nx;

    always_comb begin
        st_nx   = st;
        load_nx = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (b_wr && b_frz) st_nx = ST_HOLD;
                if (time_wr)       load_nx = 1'b1;
            end
            ST_HOLD: begin
                if (b_wr && !b_frz) begin
                    st_nx   = ST_RUN;
                    load_nx = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_load <= 1'b0;
        else        tm_load <= load_nx;
    end

    assign set_mode = (st == ST_HOLD);

    // R4
    hold_exit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && b_wr && !b_frz) |=> (tm_load && !set_mode));
    // R7
    hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && time_wr) |=> !tm_load);
    // R3
    frz_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_frz) |=> set_mode);
endmodule

// File: rtl/rtcx_csum.sv
module rtcx_csum #(
    parameter int DW    = 8,
    parameter int IDX_W = 7,
    parameter int LO    = 16,
    parameter int HI    = 45
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    old_byte,
    input  logic [DW-1:0]    new_byte,
    input  logic [2*DW-1:0]  sum_in,
    output logic             in_range,
    output logic [2*DW-1:0]  sum_out
);
    localparam int SW = 2 * DW;

    always_comb begin
        in_range = (int'(idx) >= LO) && (int'(idx) <= HI);
        sum_out  = sum_in - SW'(old_byte) + SW'(new_byte);
    end
endmodule

// File: rtl/rtcx_flags.sv
module rtcx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_c,
    input  logic [DW-1:0] flag_set,
    output logic [DW-1:0] c_val,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_val <= '0;
            irq   <= 1'b0;
        end else begin
            c_val <= (rd_c ? '0 : c_val) | flag_set;
            irq   <= (rd_c ? 1'b0 : irq) | (|flag_set);
        end
    end

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && flag_set == '0) |=> (!irq && c_val == '0));
    // R11
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> irq);
endmodule

// File: rtl/rtcx_regs.sv
module rtcx_regs
    import rtcx_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int DW       = 8,
    parameter int CS_FIRST = 16,
    parameter int CS_LAST  = 45,
    parameter int CS_HIGH  = 46,
    parameter int CS_LOW   = 47
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_a0,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                uip_set,
    input  logic                uip_clr,
    input  logic [DW-1:0]       flag_set,
    output logic                irq,
    input  logic                tc_copy,
    input  logic [N_TIME*DW-1:0] tc_bytes,
    output logic [N_TIME*DW-1:0] tm_image,
    output logic                tm_load,
    output logic [DW-1:0]       ctrl_a,
    output logic [DW-1:0]       ctrl_b
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [DW-1:0] RST_A = DW'(8'h26);
    localparam logic [DW-1:0] RST_B = DW'(8'h02);
    localparam logic [DW-1:0] RST_D = DW'(8'h80);

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             data_wr, data_rd;
    logic             set_mode;
    logic             in_range;
    logic [2*DW-1:0]  sum_out;
    logic [DW-1:0]    c_val;

    assign data_wr = bus_wr && bus_a0;
    assign data_rd = bus_rd && bus_a0;

    rtcx_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .b_wr     (data_wr && idx == IDX_W'(IDX_CTL_B)),
        .b_frz    (bus_wdata[FRZ_BIT]),
        .time_wr  (data_wr && is_time_idx(7'(idx))),
        .set_mode (set_mode),
        .tm_load  (tm_load)
    );

    rtcx_csum #(.DW(DW), .IDX_W(IDX_W), .LO(CS_FIRST), .HI(CS_LAST)) u_csum (
        .idx      (idx),
        .old_byte (mem[idx]),
        .new_byte (bus_wdata),
        .sum_in   ({mem[CS_HIGH], mem[CS_LOW]}),
        .in_range (in_range),
        .sum_out  (sum_out)
    );

    rtcx_flags #(.DW(DW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_c     (data_rd && idx == IDX_W'(IDX_STAT_C)),
        .flag_set (flag_set),
        .c_val    (c_val),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            mem[IDX_CTL_A]  <= RST_A;
            mem[IDX_CTL_B]  <= RST_B;
            mem[IDX_STAT_D] <= RST_D;
            idx <= '0;
        end else begin
            if (tc_copy && !set_mode) begin
                for (int k = 0; k < N_TIME; k++)
                    mem[slot_idx(k)] <= tc_bytes[k*DW +: DW];
            end
            if (uip_clr)                   mem[IDX_CTL_A][BUSY_BIT] <= 1'b0;
            else if (uip_set && !set_mode) mem[IDX_CTL_A][BUSY_BIT] <= 1'b1;

            if (bus_wr && !bus_a0) idx <= bus_wdata[IDX_W-1:0];
            if (data_wr) begin
                case (int'(idx))
                    IDX_CTL_A: mem[IDX_CTL_A][BUSY_BIT-1:0] <= bus_wdata[BUSY_BIT-1:0];
                    IDX_CTL_B: begin
                        if (bus_wdata[FRZ_BIT]) begin
                            mem[IDX_CTL_B] <= bus_wdata & ~(DW'(1) << UEN_BIT);
                            mem[IDX_CTL_A][BUSY_BIT] <= 1'b0;
                        end else begin
                            mem[IDX_CTL_B] <= bus_wdata;
                        end
                    end
                    IDX_STAT_C, IDX_STAT_D: ;
                    default: mem[idx] <= bus_wdata;
                endcase
                if (in_range) begin
                    mem[CS_HIGH] <= sum_out[2*DW-1:DW];
                    mem[CS_LOW]  <= sum_out[DW-1:0];
                end
            end
        end
    end

    always_comb begin
        if (!bus_a0)                          bus_rdata = '1;
        else if (idx == IDX_W'(IDX_STAT_C))   bus_rdata = c_val;
        else                                  bus_rdata = mem[idx];
    end

    for (genvar k = 0; k < N_TIME; k++) begin : g_img
        assign tm_image[k*DW +: DW] = mem[slot_idx(k)];
    end

    assign ctrl_a = mem[IDX_CTL_A];
    assign ctrl_b = mem[IDX_CTL_B];

    // R2
    busy_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == IDX_W'(IDX_CTL_A) && !uip_set && !uip_clr)
        |=> ctrl_a[BUSY_BIT] == $past(ctrl_a[BUSY_BIT]));
    // R3
    frz_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == IDX_W'(IDX_CTL_B) && bus_wdata[FRZ_BIT])
        |=> (!ctrl_b[UEN_BIT] && !ctrl_a[BUSY_BIT]));
    // R3
    mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode == ctrl_b[FRZ_BIT]);
    // R5
    stat_c_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == IDX_W'(IDX_STAT_C) && flag_set == '0) |=> $stable(c_val));
    // R9
    csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && (in_range || idx == IDX_W'(CS_HIGH) || idx == IDX_W'(CS_LOW)))
        |=> $stable({mem[CS_HIGH], mem[CS_LOW]}));
endmodule

// File: tb/sim_rtcx_regs.sv
`timescale 1ns/1ps
module sim_rtcx_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        uip_set = 1'b0, uip_clr = 1'b0;
    logic [7:0]  flag_set = '0;
    logic        irq;
    logic        tc_copy = 1'b0;
    logic [55:0] tc_bytes = '0;
    logic [55:0] tm_image;
    logic        tm_load;
    logic [7:0]  ctrl_a, ctrl_b;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    rtcx_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uip_set(uip_set), .uip_clr(uip_clr),
        .flag_set(flag_set), .irq(irq), .tc_copy(tc_copy), .tc_bytes(tc_bytes),
        .tm_image(tm_image), .tm_load(tm_load), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 64'(bus_rdata), 64'(e));
        end
    end

    task automatic wr(bit a0, logic [7:0] d);
        @(posedge clk); #1;
        bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(bit a0, logic [7:0] exp, string tag, logic [7:0] fl = 8'h00);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_a0 = a0; bus_rd = 1'b1; flag_set = fl;
        @(posedge clk); #1;
        bus_rd = 1'b0; flag_set = 8'h00;
    endtask

    task automatic rdreg(logic [7:0] i, logic [7:0] exp, string tag);
        wr(1'b0, i);
        rd(1'b1, exp, tag);
    endtask

    task automatic wreg(logic [7:0] i, logic [7:0] d);
        wr(1'b0, i);
        wr(1'b1, d);
    endtask

    task automatic pulse_uip(bit s, bit c);
        @(posedge clk); #1; uip_set = s; uip_clr = c;
        @(posedge clk); #1; uip_set = 1'b0; uip_clr = 1'b0;
    endtask

    task automatic pulse_flags(logic [7:0] f);
        @(posedge clk); #1; flag_set = f;
        @(posedge clk); #1; flag_set = 8'h00;
    endtask

    task automatic pulse_copy(logic [55:0] v);
        @(posedge clk); #1; tc_bytes = v; tc_copy = 1'b1;
        @(posedge clk); #1; tc_copy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 reset values
        chk("R8 irq", 64'(irq), 64'd0);
        rdreg(8'h8A, 8'h26, "R8/R1 ctrl A via masked index");
        rd(1'b0, 8'hFF, "R1 even read");
        rdreg(8'h0B, 8'h02, "R8 ctrl B");
        rdreg(8'h0C, 8'h00, "R8 stat C");
        rdreg(8'h0D, 8'h80, "R8 stat D");

        // R2 busy bit
        pulse_uip(1'b1, 1'b0);
        chk("R2 uip_set", 64'(ctrl_a), 64'hA6);
        wreg(8'h0A, 8'h00);
        rd(1'b1, 8'h80, "R2 busy kept on write 00");
        wr(1'b1, 8'h26);
        chk("R2 busy kept on write 26", 64'(ctrl_a), 64'hA6);
        pulse_uip(1'b0, 1'b1);
        chk("R2 uip_clr", 64'(ctrl_a), 64'h26);

        // R5 status writes ignored
        wreg(8'h0C, 8'hFF);
        rd(1'b1, 8'h00, "R5 stat C write ignored");
        chk("R5 irq", 64'(irq), 64'd0);
        wreg(8'h0D, 8'h00);
        rd(1'b1, 8'h80, "R5 stat D write ignored");

        // R7 time write in run
        wreg(8'h00, 8'h45);
        chk("R7 load in run", 64'(tm_load), 64'd1);
        chk("R7 image", 64'(tm_image), 64'h45);

        // R3 enter freeze
        pulse_uip(1'b1, 1'b0);
        chk("R3 busy before", 64'(ctrl_a), 64'hA6);
        wreg(8'h0B, 8'h92);
        chk("R3 no load", 64'(tm_load), 64'd0);
        chk("R3 ctrl B forced", 64'(ctrl_b), 64'h82);
        chk("R3 busy cleared", 64'(ctrl_a), 64'h26);
        pulse_uip(1'b1, 1'b0);
        chk("R2 uip_set ignored in freeze", 64'(ctrl_a), 64'h26);

        // R7 time write in hold
        wreg(8'h02, 8'h30);
        chk("R7 no load in hold", 64'(tm_load), 64'd0);
        rd(1'b1, 8'h30, "R7 stored in hold");

        // R10 copy blocked in hold
        pulse_copy(56'h11111111111111);
        chk("R10 copy blocked", 64'(tm_image), 64'h3045);

        // R4 exit freeze
        wreg(8'h0B, 8'h02);
        chk("R4 load on exit", 64'(tm_load), 64'd1);
        wr(1'b1, 8'h06);
        chk("R4 no load when already run", 64'(tm_load), 64'd0);

        // R10 copy in run
        pulse_copy(56'h24123105235958);
        chk("R10 copy", 64'(tm_image), 64'h24123105235958);
        rdreg(8'h04, 8'h23, "R10 hours byte");

        // R11 / R6 flags and clear-on-read
        pulse_flags(8'h90);
        chk("R11 irq up", 64'(irq), 64'd1);
        rdreg(8'h0C, 8'h90, "R6 read C value");
        chk("R6 irq released", 64'(irq), 64'd0);
        rd(1'b1, 8'h00, "R6 C cleared");
        pulse_flags(8'hA0);
        rd(1'b1, 8'hA0, "R6 read with new flag", 8'hC0);
        chk("R6 irq kept for new flag", 64'(irq), 64'd1);
        rd(1'b1, 8'hC0, "R6 new flag kept");

        // R9 checksum
        wreg(8'h10, 8'hFF);
        wreg(8'h2D, 8'h80);
        rdreg(8'h2E, 8'h01, "R9 high after two writes");
        rdreg(8'h2F, 8'h7F, "R9 low after two writes");
        wreg(8'h10, 8'h01);
        rdreg(8'h2F, 8'h81, "R9 low after overwrite");
        rdreg(8'h2E, 8'h00, "R9 high after overwrite");
        wreg(8'h2C, 8'hFF);
        wreg(8'h0F, 8'h55);
        rdreg(8'h2E, 8'h01, "R9 high, out-of-range write");
        rdreg(8'h2F, 8'h80, "R9 low, out-of-range write");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule